// File: doc/BRIEF.md
# Floppy Controller Digital Input Status Register

This block is the read-only status register that a floppy disk controller exposes at offset 7 of its address window. A read at that offset returns the drive's disk-change state in the top bit. In PS/2 presentation, the low bits also carry the current two-bit data-rate code, an active-low high-density flag and four filler bits. In AT presentation, only the top bit is driven and the seven low bits are left floating. Each bit has its own output enable, so the host bus can hold undriven bits at high impedance.

The data-rate code is stored here. It is loaded from a dedicated write port. A hardware reset sets the code to the 250 kbps value. A software reset leaves the code alone and only returns the disk-change synchroniser to its idle state. The disk-change cable signal is active low and arrives from outside the clock domain. It passes through a two-stage synchroniser before it is inverted. A force input can then override it so that a change is always reported.

Top module: `floppy_din_status`

## Requirements
- R1: All output enables and all read data bits are 0 unless `rdStb` is 1 and `addr` equals 7.
- R2: During a selected read with `psMode`=0 (AT), `rdOe` is 8'h80 and `rdData[6:0]` is 0.
- R3: During a selected read with `psMode`=1 (PS/2), `rdOe` is 8'hFF and `rdData[6:3]` reads 4'b1111.
- R4: `rdData[7]` is the inverse of `dskChgN` as seen after two rising clock edges. A change on the cable that is set up before edge k first shows on the output after edge k+1.
- R5: While `forceChg` is 1, a selected read returns `rdData[7]`=1, whatever the cable level.
- R6: In PS/2 reads, `rdData[2:1]` is the stored rate code: 00=500 kbps, 01=300 kbps, 10=250 kbps, 11=1 Mbps.
- R7: In PS/2 reads, `rdData[0]` is 1 for codes 01 and 10, and 0 for codes 00 and 11.
- R8: While `hwRstN` is low, the rate code becomes 10 and both synchroniser stages become 1, so no change is reported.
- R9: When `rateWe` is 1 at a rising edge, `rateIn` becomes the stored rate code after that edge.
- R10: A rising edge with `swRst`=1 and `rateWe`=0 leaves the rate code unchanged. It sets both synchroniser stages to 1, so `rdData[7]` reads 0 (with `forceChg`=0) right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| hwRstN | input | 1 | Asynchronous hardware reset, active low |
| swRst | input | 1 | Synchronous software reset, active high |
| addr | input | 3 | Register offset within the controller's address window |
| rdStb | input | 1 | Read strobe from the host bus |
| psMode | input | 1 | Interface presentation: 1 = PS/2, 0 = AT |
| rateWe | input | 1 | Load strobe for the data-rate code |
| rateIn | input | 2 | Data-rate code to load |
| forceChg | input | 1 | Forces a disk-change indication |
| dskChgN | input | 1 | Disk-change line from the drive cable, active low, asynchronous |
| rdData | output | 8 | Read data; bits whose enable is off are driven 0 |
| rdOe | output | 8 | Per-bit output enable for the read data |

## Verification
The assertions assume that `addr`, `rdStb`, `psMode` and `forceChg` only change away from the rising edge. They also assume that `swRst` and `rateWe` are never raised together. The bench drives every input on the falling edge and pulses software reset only while the rate strobe is low. The synchroniser check assumes the cable level is held for at least two edges before a read. The bench therefore waits three edges after each cable change before it sweeps the read combinations, and it probes the two-edge latency on its own.

// File: rtl/fdcin_pkg.sv
package fdcin_pkg;

  typedef enum logic [1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rateCode_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic readSel;   // this register is being read
    logic psView;    // PS/2 bit layout selected
    logic loadRate;  // capture a new rate code
    logic syncInit;  // return synchroniser to idle
  } dirStrobes_t;

endpackage

// File: rtl/fdcin_ctrl.sv
module fdcin_ctrl
  import fdcin_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int REG_OFS = 7
) (
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              psMode,
  input  logic              rateWe,
  input  logic              swRst,
  output dirStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] OFS = REG_OFS[ADDR_W-1:0];

  logic hit;

  always_comb begin
    hit              = rdStb && (addr == OFS);
    strobes.readSel  = hit;
    strobes.psView   = hit && psMode;
    strobes.loadRate = rateWe;
    strobes.syncInit = swRst;
  end

endmodule

// File: rtl/fdcin_datapath.sv
module fdcin_datapath
  import fdcin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILL_LO     = 3,
  parameter int FILL_HI     = 6
) (
  input  logic        clk,
  input  logic        hwRstN,
  input  dirStrobes_t strobes,
  input  logic [1:0]  rateIn,
  input  logic        forceChg,
  input  logic        dskChgN,
  output logic [7:0]  rdData,
  output logic [7:0]  rdOe,
  output logic [1:0]  rateCode
);

  localparam int LAST = SYNC_STAGES - 1;

  rateCode_e rateQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic chgFlag;
  logic nHighDens;
  logic [7:0] psWord;
  logic [7:0] atWord;
  logic [7:0] fillMask;

  // rate code: hardware reset only
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      rateQ <= RATE_250K;
    end else if (strobes.loadRate) begin
      rateQ <= rateCode_e'(rateIn);
    end
  end

  // cable synchroniser, idles high (no change)
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      syncQ <= '1;
    end else if (strobes.syncInit) begin
      syncQ <= '1;
    end else begin
      for (int i = LAST; i > 0; i--) begin
        syncQ[i] <= syncQ[i-1];
      end
      syncQ[0] <= dskChgN;
    end
  end

  // filler bits of the PS/2 layout
  for (genvar g = 0; g < 8; g++) begin : g_fill
    if (g >= FILL_LO && g <= FILL_HI) begin : g_on
      assign fillMask[g] = 1'b1;
    end else begin : g_off
      assign fillMask[g] = 1'b0;
    end
  end

  always_comb begin
    chgFlag   = forceChg | ~syncQ[LAST];
    nHighDens = (rateQ == RATE_300K) || (rateQ == RATE_250K);
    psWord    = fillMask | {chgFlag, 4'b0000, rateQ, nHighDens};
    atWord    = {chgFlag, 7'b0};
    if (!strobes.readSel) begin
      rdOe = 8'h00;
    end else if (strobes.psView) begin
      rdOe = 8'hFF;
    end else begin
      rdOe = 8'h80;
    end
    rdData   = rdOe & (strobes.psView ? psWord : atWord);
    rateCode = rateQ;
  end

endmodule

// File: rtl/floppy_din_status.sv
module floppy_din_status
  import fdcin_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int REG_OFS     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              swRst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              psMode,
  input  logic              rateWe,
  input  logic [1:0]        rateIn,
  input  logic              forceChg,
  input  logic              dskChgN,
  output logic [7:0]        rdData,
  output logic [7:0]        rdOe
);

  dirStrobes_t strobes;
  logic [1:0]  rateCode;

  fdcin_ctrl #(
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS)
  ) ctrl (
    .rdStb  (rdStb),
    .addr   (addr),
    .psMode (psMode),
    .rateWe (rateWe),
    .swRst  (swRst),
    .strobes(strobes)
  );

  fdcin_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .strobes (strobes),
    .rateIn  (rateIn),
    .forceChg(forceChg),
    .dskChgN (dskChgN),
    .rdData  (rdData),
    .rdOe    (rdOe),
    .rateCode(rateCode)
  );

endmodule

// File: rtl/floppy_din_status_chk.sv
module floppy_din_status_chk (
  input logic       clk,
  input logic       hwRstN,
  input logic       swRst,
  input logic       rateWe,
  input logic [2:0] addr,
  input logic       rdStb,
  input logic       psMode,
  input logic       forceChg,
  input logic [7:0] rdData,
  input logic [7:0] rdOe,
  input logic [1:0] rateCode
);

  logic sel;
  assign sel = rdStb && (addr == 3'd7);

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    !sel |-> (rdOe == 8'h00 && rdData == 8'h00));

  // R2
  at_layout_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (sel && !psMode) |-> (rdOe == 8'h80 && rdData[6:0] == 7'h00));

  // R3
  ps_layout_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (sel && psMode) |-> (rdOe == 8'hFF && rdData[6:3] == 4'hF));

  // R5
  force_chg_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (sel && forceChg) |-> rdData[7]);

  // R7
  density_flag_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (sel && psMode) |-> (rdData[0] == (rdData[2] ^ rdData[1])));

  // R10
  soft_reset_keeps_rate_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (swRst && !rateWe) |=> $stable(rateCode));

endmodule

bind floppy_din_status floppy_din_status_chk chk (
  .clk     (clk),
  .hwRstN  (hwRstN),
  .swRst   (swRst),
  .rateWe  (rateWe),
  .addr    (addr),
  .rdStb   (rdStb),
  .psMode  (psMode),
  .forceChg(forceChg),
  .rdData  (rdData),
  .rdOe    (rdOe),
  .rateCode(rateCode)
);

// File: tb/floppy_din_status_test.sv
module floppy_din_status_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       hwRstN = 1'b0;
  logic       swRst = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       rdStb = 1'b0;
  logic       psMode = 1'b0;
  logic       rateWe = 1'b0;
  logic [1:0] rateIn = 2'b00;
  logic       forceChg = 1'b0;
  logic       dskChgN = 1'b1;
  logic [7:0] rdData;
  logic [7:0] rdOe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  floppy_din_status uut (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .swRst   (swRst),
    .addr    (addr),
    .rdStb   (rdStb),
    .psMode  (psMode),
    .rateWe  (rateWe),
    .rateIn  (rateIn),
    .forceChg(forceChg),
    .dskChgN (dskChgN),
    .rdData  (rdData),
    .rdOe    (rdOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expWord(input bit ps, input logic [1:0] rate, input bit chg);
    bit nhd;
    nhd = (rate == 2'b01) || (rate == 2'b10);
    return ps ? {chg, 4'hF, rate, nhd} : {chg, 7'b0};
  endfunction

  function automatic logic [7:0] expOe(input bit rd, input logic [2:0] a, input bit ps);
    if (!(rd && a == 3'd7)) return 8'h00;
    return ps ? 8'hFF : 8'h80;
  endfunction

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic psRead(output logic [7:0] d);
    addr = 3'd7; rdStb = 1'b1; psMode = 1'b1;
    #1 d = rdData;
  endtask

  task automatic loadRate(input logic [1:0] r);
    rateIn = r; rateWe = 1'b1;
    edges(1);
    rateWe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] e;
    // reset state, R8
    edges(2);
    psRead(d);
    check(d == 8'h7D, "R8 reset rate and idle sync", d, 8'h7D);
    rdStb = 1'b0;
    hwRstN = 1'b1;
    edges(1);
    psRead(d);
    check(d == 8'h7D, "R8 after reset release", d, 8'h7D);

    // sweep, R1 R2 R3 R5 R6 R7 R9
    for (int r = 0; r < 4; r++) begin
      loadRate(2'(r));
      for (int cab = 0; cab < 2; cab++) begin
        dskChgN = cab[0];
        edges(3);
        for (int f = 0; f < 2; f++) begin
          for (int ps = 0; ps < 2; ps++) begin
            for (int a = 0; a < 8; a++) begin
              for (int rd = 0; rd < 2; rd++) begin
                logic [7:0] eo;
                forceChg = f[0]; psMode = ps[0]; addr = 3'(a); rdStb = rd[0];
                #1;
                eo = expOe(rd[0], 3'(a), ps[0]);
                e  = eo & expWord(ps[0], 2'(r), f[0] | ~cab[0]);
                check(rdOe == eo, (eo == 0) ? "R1 enables" : (ps != 0) ? "R3 enables" : "R2 enables", rdOe, eo);
                check(rdData == e, (eo == 0) ? "R1 data" : (ps != 0) ? "R6/R7/R9 data" : "R2 data", rdData, e);
                if (eo != 0)
                  check(rdData[7] == (f[0] | ~cab[0]), (f != 0) ? "R5 force" : "R4 cable", {7'b0, rdData[7]}, {7'b0, f[0] | ~cab[0]});
                edges(1);
              end
            end
          end
        end
      end
    end
    forceChg = 1'b0;

    // R4 latency
    dskChgN = 1'b1; edges(3);
    dskChgN = 1'b0;
    edges(1); psRead(d);
    check(d[7] == 1'b0, "R4 one edge not yet", d, {1'b0, d[6:0]});
    edges(1); psRead(d);
    check(d[7] == 1'b1, "R4 two edges visible", d, {1'b1, d[6:0]});

    // R10 software reset
    loadRate(2'b11);
    swRst = 1'b1; edges(1); swRst = 1'b0;
    psRead(d);
    e = expWord(1'b1, 2'b11, 1'b0);
    check(d == e, "R10 sync idle, rate kept", d, e);
    edges(2); psRead(d);
    e = expWord(1'b1, 2'b11, 1'b1);
    check(d == e, "R10 cable returns", d, e);

    // R8 hardware reset mid-run
    loadRate(2'b00);
    psRead(d);
    e = expWord(1'b1, 2'b00, 1'b1);
    check(d == e, "R9 load 500k", d, e);
    hwRstN = 1'b0; #1;
    psRead(d);
    e = expWord(1'b1, 2'b10, 1'b0);
    check(d == e, "R8 hardware reset", d, e);
    edges(1); hwRstN = 1'b1;
    edges(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule